// File: doc/BRIEF.md
# Debug Run-Control Request Register

This block is a write-only control register for a debugger that halts and restarts a processor core. A single-cycle bus write is turned into request levels that stay asserted until the core acknowledges them. Some bits instead produce one-cycle strobes that clear sticky bits in a separate status register. Each request bit has its own rule for when a write is dropped: a halt is dropped while the core is in debug state, a restart is dropped while it is running, and an abandon-memory request is dropped while debug is disabled.

The block also keeps two flags that the debugger polls after making a request. The halted flag mirrors the core's debug-state input, one cycle late. The restarted flag is cleared when a restart request is accepted and set when the core reports that it has left debug state. A read of the register always returns zero.

Top module: `dbg_run_ctrl`

## Requirements
- R1: A synchronous active-low reset drives every request, strobe and status flag low on the next clock edge.
- R2: `rd_data` is zero at all times, and bits [31:5] of a write have no effect on any output.
- R3: A write with bit 0 set while `in_debug` is low raises `halt_req` on the next edge. It stays high until a cycle with `entry_ack` high, and falls on the edge that closes that cycle. `entry_ack` takes priority over a new set.
- R4: A write with bit 0 set while `in_debug` is high leaves `halt_req` unchanged.
- R5: A write with bit 1 set while `in_debug` is high raises `restart_req` on the next edge. It stays high until a cycle with `exit_ack` high, and falls on the edge that closes that cycle. `exit_ack` takes priority over a new set.
- R6: A write with bit 1 set while `in_debug` is low leaves `restart_req` unchanged.
- R7: A write with bit 2 set drives `clr_sticky_exc` high for exactly the one cycle after the write. That strobe clears status bits [8:6].
- R8: A write with bit 3 set drives `clr_sticky_adv` high for exactly the one cycle after the write. That strobe clears status bit 25.
- R9: A write with bit 4 set while `dbg_en` is high raises `abandon_req`. It stays high until `entry_ack`, which is its only clear. Abandoning a transaction never produces an exception output.
- R10: A write with bit 4 set while `dbg_en` is low leaves `abandon_req` unchanged.
- R11: `stat_halted` (polled as status bit 0) equals `in_debug` as it was one cycle earlier.
- R12: `stat_restarted` (polled as status bit 1) falls on the edge after a restart write is accepted and rises on the edge after `exit_ack`. An accepted write wins if both happen in the same cycle.
- R13: When bits 0 and 1 are set in the same write, each is judged on its own against `in_debug`, so only one of the two requests can be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, always zero |
| in_debug | input | 1 | Core is in debug state |
| dbg_en | input | 1 | Invasive debug permitted |
| entry_ack | input | 1 | Core reports debug-state entry |
| exit_ack | input | 1 | Core reports debug-state exit |
| halt_req | output | 1 | Held halt request |
| restart_req | output | 1 | Held restart request |
| abandon_req | output | 1 | Held abandon-memory request |
| clr_sticky_exc | output | 1 | One-cycle clear of sticky exception bits |
| clr_sticky_adv | output | 1 | One-cycle clear of sticky pipeline-advance bit |
| stat_halted | output | 1 | Halted status flag |
| stat_restarted | output | 1 | Restarted status flag |

## Verification
The assertions assume nothing about the core's protocol. They relate only the write, the acknowledges and the registered outputs, so they hold for any sequence of inputs. The bench still behaves like a plausible core. It pulses `entry_ack` for one cycle only while a halt is pending and the core is running, and raises `in_debug` one cycle later. It pulses `exit_ack` only while a restart is pending in debug state, then drops `in_debug`. Alongside that core, `dbg_en`, `wr_en` and the data bits are driven at random, and a reset is applied part way through the run.

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl #(
  parameter int DATA_W  = 32,
  parameter int HALT_B  = 0,
  parameter int RSTRT_B = 1,
  parameter int CEXC_B  = 2,
  parameter int CADV_B  = 3,
  parameter int ABN_B   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              in_debug,
  input  logic              dbg_en,
  input  logic              entry_ack,
  input  logic              exit_ack,
  output logic              halt_req,
  output logic              restart_req,
  output logic              abandon_req,
  output logic              clr_sticky_exc,
  output logic              clr_sticky_adv,
  output logic              stat_halted,
  output logic              stat_restarted
);

  logic halt_set, rstrt_set, abn_set;

  assign rd_data   = '0;
  assign halt_set  = wr_en && wr_data[HALT_B]  && !in_debug;
  assign rstrt_set = wr_en && wr_data[RSTRT_B] &&  in_debug;
  assign abn_set   = wr_en && wr_data[ABN_B]   &&  dbg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_req       <= 1'b0;
      restart_req    <= 1'b0;
      abandon_req    <= 1'b0;
      clr_sticky_exc <= 1'b0;
      clr_sticky_adv <= 1'b0;
      stat_halted    <= 1'b0;
      stat_restarted <= 1'b0;
    end else begin
      halt_req       <= !entry_ack && (halt_req || halt_set);
      restart_req    <= !exit_ack && (restart_req || rstrt_set);
      abandon_req    <= !entry_ack && (abandon_req || abn_set);
      clr_sticky_exc <= wr_en && wr_data[CEXC_B];
      clr_sticky_adv <= wr_en && wr_data[CADV_B];
      stat_halted    <= in_debug;
      if (rstrt_set)     stat_restarted <= 1'b0;
      else if (exit_ack) stat_restarted <= 1'b1;
    end
  end

  AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !entry_ack |=> halt_req); // R3
  AST_HALT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    entry_ack |=> !halt_req && !abandon_req); // R3
  AST_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug && !halt_req |=> !halt_req); // R4
  AST_RSTRT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req && !exit_ack |=> restart_req); // R5
  AST_RSTRT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !in_debug && !restart_req |=> !restart_req); // R6
  AST_CEXC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[CEXC_B]) |=> !clr_sticky_exc); // R7
  AST_CADV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[CADV_B]) |=> !clr_sticky_adv); // R8
  AST_ABN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en && !abandon_req |=> !abandon_req); // R10
  AST_RESTARTED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ack && !(wr_en && wr_data[RSTRT_B]) |=> stat_restarted); // R12
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[HALT_B] && wr_data[RSTRT_B] && !halt_req && !restart_req
    && !entry_ack && !exit_ack |=> $countones({halt_req, restart_req}) == 1); // R13

endmodule

// File: tb/dbg_run_ctrl_tb_top.sv
module dbg_run_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0, wr_en = 1'b0, in_debug = 1'b0, dbg_en = 1'b0;
  logic        entry_ack = 1'b0, exit_ack = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic halt_req, restart_req, abandon_req, clr_sticky_exc, clr_sticky_adv;
  logic stat_halted, stat_restarted;

  dbg_run_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .in_debug(in_debug), .dbg_en(dbg_en), .entry_ack(entry_ack), .exit_ack(exit_ack),
    .halt_req(halt_req), .restart_req(restart_req), .abandon_req(abandon_req),
    .clr_sticky_exc(clr_sticky_exc), .clr_sticky_adv(clr_sticky_adv),
    .stat_halted(stat_halted), .stat_restarted(stat_restarted)
  );

  int n_tests = 0, n_fail = 0;
  bit started = 0;
  bit m_halt, m_rst, m_abn, m_cexc, m_cadv, m_hlt, m_rsd;

  // Behavioural reference, updated from the requirements at each edge
  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      {m_halt, m_rst, m_abn, m_cexc, m_cadv, m_hlt, m_rsd} <= '0;
    end else begin
      if (entry_ack) m_halt <= 0;
      else if (wr_en && wr_data[0] && !in_debug) m_halt <= 1;
      if (exit_ack) m_rst <= 0;
      else if (wr_en && wr_data[1] && in_debug) m_rst <= 1;
      if (entry_ack) m_abn <= 0;
      else if (wr_en && wr_data[4] && dbg_en) m_abn <= 1;
      m_cexc <= wr_en && wr_data[2];
      m_cadv <= wr_en && wr_data[3];
      m_hlt  <= in_debug;
      if (wr_en && wr_data[1] && in_debug) m_rsd <= 0;
      else if (exit_ack) m_rsd <= 1;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    check("R2 rd_data", rd_data, 32'h0);
    check("R3/R4/R13 halt_req", {31'b0, halt_req}, {31'b0, m_halt});
    check("R5/R6/R13 restart_req", {31'b0, restart_req}, {31'b0, m_rst});
    check("R9/R10 abandon_req", {31'b0, abandon_req}, {31'b0, m_abn});
    check("R7 clr_sticky_exc", {31'b0, clr_sticky_exc}, {31'b0, m_cexc});
    check("R8 clr_sticky_adv", {31'b0, clr_sticky_adv}, {31'b0, m_cadv});
    check("R11 stat_halted", {31'b0, stat_halted}, {31'b0, m_hlt});
    check("R12 stat_restarted", {31'b0, stat_restarted}, {31'b0, m_rsd});
  end

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  bit ent_pend = 0, ex_pend = 0;

  initial begin
    dbg_en = 1;
    repeat (3) @(negedge clk);
    // R1: everything low after reset
    check("R1 outputs after reset",
          {25'b0, halt_req, restart_req, abandon_req, clr_sticky_exc, clr_sticky_adv,
           stat_halted, stat_restarted}, 32'h0);
    rst_n = 1;
    // Directed: high bits ignored (R2), strobes (R7, R8), halt+restart together (R13)
    wr(32'hFFFF_FFE0);
    wr(32'h0000_000C);
    wr(32'h0000_0003);
    check("R13 only halt taken when running", {30'b0, halt_req, restart_req}, 32'h2);
    dbg_en = 0; wr(32'h10);
    check("R10 abandon ignored", {31'b0, abandon_req}, 32'h0);
    dbg_en = 1; wr(32'h10);
    entry_ack = 1; @(negedge clk); entry_ack = 0; in_debug = 1;
    @(negedge clk);
    wr(32'h0000_0003);
    check("R13 only restart taken in debug", {30'b0, halt_req, restart_req}, 32'h1);
    exit_ack = 1; @(negedge clk); exit_ack = 0; in_debug = 0;
    @(negedge clk);
    // Random phase with a small core model
    for (int i = 0; i < 6000; i++) begin
      entry_ack = 0; exit_ack = 0;
      if (i == 3000) rst_n = 0;
      if (i == 3003) rst_n = 1;
      if (ent_pend) begin in_debug = 1; ent_pend = 0; end
      else if (ex_pend) begin in_debug = 0; ex_pend = 0; end
      else if (!in_debug && halt_req && $urandom_range(3) == 0) begin
        entry_ack = 1; ent_pend = 1;
      end else if (in_debug && restart_req && $urandom_range(3) == 0) begin
        exit_ack = 1; ex_pend = 1;
      end
      dbg_en  = ($urandom_range(5) != 0);
      wr_en   = ($urandom_range(2) == 0);
      wr_data = $urandom;
      @(negedge clk);
    end
    wr_en = 0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule